// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Configuration Lock

This block is a watchdog built around a 12-bit down-counter. A selectable power-of-two prescaler paces the counter. Software sets a reload value, a window (delta) value, the prescaler, a reset enable and two halt controls through a small register port. When the counter steps below zero it reloads by itself, sets a sticky underflow flag and, if reset is enabled, pulses the reset output. Software restarts the count with a keyed reload command.

A reload issued while the count is still above the delta value is early. An early reload is treated as a fault, so a service loop that has locked up and reloads without pause is caught. The fault sets a sticky error flag and can pulse the reset output too. The configuration registers sit behind a 16-bit unlock key. A sleep input or a debug-halt input, each gated by its own control bit, freezes the counter and the prescaler.

A small state machine tracks the block's condition. ST_RUN means counting. ST_FROZEN means a halt is in force. ST_TRIP is the single cycle that drives the reset output. The transitions are as follows:
- RUN→FROZEN when a gated halt becomes active.
- FROZEN→RUN when the halt clears.
- Any state →TRIP on an underflow or a window error.
- TRIP→RUN or TRIP→FROZEN on the next cycle with no event, depending on the halt.
- TRIP→TRIP when events fall in back-to-back cycles.

Top module: `wdt_window_top`

Register map (`addr`, `rd_addr`):
- 0: command. Write only; reads return 0.
- 1: config A. Bits [11:0] hold the reload value, bit 16 the reset enable, bit 17 the sleep-halt enable and bit 18 the debug-halt enable.
- 2: config B. Bits [11:0] hold the delta value and bits [14:12] the prescaler exponent.
- 3: lock.
- 4: status. Bit 0 is underflow and bit 1 is error.
- 5: count. Read only, in bits [11:0].

## Requirements
- R1: After reset:
  - reload, delta and count are 0xFFF and the prescaler exponent is 7;
  - the reset, sleep-halt and debug-halt enables are 0 and the lock is off;
  - both flags are 0 and `wdt_rst_o` is low.
- R2: A write to address 3 turns the lock on when wdata[15:0] ≠ 0x35CA and turns it off when wdata[15:0] = 0x35CA. Bit 0 of a read at address 3 returns 1 while the lock is on.
- R3: While the lock is on, writes to addresses 1 and 2 leave their contents unchanged, and reads still return the stored values. Writes to the command, status and lock addresses are not gated by the lock.
- R4: A reload happens only on a write to address 0 with wdata[0]=1 and wdata[31:16]=0x5FA0 in the same word. It loads the count with the reload value and restarts the prescaler phase. Any other command write has no effect.
- R5: With exponent n, the count falls by one once every 2^n unfrozen cycles, for n from 0 to 7.
- R6: A decrement step taken at count 0 loads the reload value instead and sets the underflow flag (status bit 0).
- R7: A valid reload taken while the count is greater than delta, and delta is less than reload, sets the error flag (status bit 1). If delta ≥ reload, no reload sets the error flag.
- R8: Both flags stay set until a status write with 1 in that flag's bit clears it. A new event in the same cycle wins over the clear.
- R9: `wdt_rst_o` goes high for the one cycle after an underflow or window error, and only while the reset enable is 1.
- R10: While the sleep-halt enable is 1 and `sleep_i` is high, the count and the prescaler phase hold. Counting resumes from the held value once the condition clears.
- R11: While the debug-halt enable is 1 and `dbg_halt_i` is high, the count and the prescaler phase hold in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Write address |
| wdata | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rdata | output | 32 | Read data for `rd_addr`, combinational |
| sleep_i | input | 1 | Sleep indication |
| dbg_halt_i | input | 1 | Debug halt request |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench targets these corner cases:
- Early reloads against late ones, and windows where delta is not below the reload value. A design that compared with the wrong sign, or ignored the disable case, would flag good reloads or miss deadlocked ones.
- Command words with a wrong key or a clear request bit. A design that decoded these loosely would accept them as reloads.
- Configuration writes while locked, and prescaler exponents 0, 2 and 7. An off-by-one in the divider would drift the count within a few periods.
- Sleep and debug halts with their enables on and off, and reset pulses with the reset enable cleared. An error here would let the count keep moving while frozen, or raise reset when it is disabled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    // register addresses
    localparam int ADR_CMD  = 0;
    localparam int ADR_CFGA = 1;
    localparam int ADR_CFGB = 2;
    localparam int ADR_LOCK = 3;
    localparam int ADR_STAT = 4;
    localparam int ADR_CNT  = 5;

    // field positions
    localparam int CFGA_REN_BIT  = 16;
    localparam int CFGA_SHLT_BIT = 17;
    localparam int CFGA_DBG_BIT  = 18;
    localparam int CFGB_PSC_LSB  = 12;
    localparam int CFG_TOP_BIT   = 18;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FROZEN = 2'd1,
        ST_TRIP   = 2'd2
    } wdt_state_e;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int          CNT_W      = 12,
    parameter int          PSC_W      = 3,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 3,
    parameter int          KEY_W      = 16,
    parameter logic [15:0] UNLOCK_KEY = 16'h35CA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              uf_evt_i,
    input  logic              err_evt_i,
    output logic [CNT_W-1:0]  reload_val_o,
    output logic [CNT_W-1:0]  delta_o,
    output logic [PSC_W-1:0]  psc_o,
    output logic              ren_o,
    output logic              shlt_o,
    output logic              dbg_en_o,
    output logic              prot_o,
    output logic              uf_flag_o,
    output logic              err_flag_o
);
    logic wr_cfga, wr_cfgb, wr_lock, wr_stat;
    logic unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:CFG_TOP_BIT+1];

    assign wr_cfga = wr_en && (addr == ADDR_W'(ADR_CFGA)) && !prot_o;
    assign wr_cfgb = wr_en && (addr == ADDR_W'(ADR_CFGB)) && !prot_o;
    assign wr_lock = wr_en && (addr == ADDR_W'(ADR_LOCK));
    assign wr_stat = wr_en && (addr == ADDR_W'(ADR_STAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_val_o <= '1;
            delta_o      <= '1;
            psc_o        <= '1;
            ren_o        <= 1'b0;
            shlt_o       <= 1'b0;
            dbg_en_o     <= 1'b0;
            prot_o       <= 1'b0;
        end else begin
            if (wr_cfga) begin
                reload_val_o <= wdata[CNT_W-1:0];
                ren_o        <= wdata[CFGA_REN_BIT];
                shlt_o       <= wdata[CFGA_SHLT_BIT];
                dbg_en_o     <= wdata[CFGA_DBG_BIT];
            end
            if (wr_cfgb) begin
                delta_o <= wdata[CNT_W-1:0];
                psc_o   <= wdata[CFGB_PSC_LSB +: PSC_W];
            end
            if (wr_lock) begin
                prot_o <= (wdata[KEY_W-1:0] != UNLOCK_KEY);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uf_flag_o  <= 1'b0;
            err_flag_o <= 1'b0;
        end else begin
            uf_flag_o  <= uf_evt_i  || (uf_flag_o  && !(wr_stat && wdata[0]));
            err_flag_o <= err_evt_i || (err_flag_o && !(wr_stat && wdata[1]));
        end
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [PSC_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int PRE_W = (1 << PSC_W) - 1;

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(sel_i));
        end
    end

    assign tick_o = run_i && ((phase_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            phase_q <= phase_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic [CNT_W-1:0] delta_i,
    output logic [CNT_W-1:0] count_o,
    output logic             uf_evt_o,
    output logic             err_evt_o
);
    logic window_on;

    assign window_on = delta_i < reload_val_i;
    assign uf_evt_o  = tick_i && !reload_i && (count_o == '0);
    assign err_evt_o = reload_i && window_on && (count_o > delta_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '1;
        end else if (reload_i) begin
            count_o <= reload_val_i;
        end else if (tick_i) begin
            if (count_o == '0) begin
                count_o <= reload_val_i;
            end else begin
                count_o <= count_o - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
    import wdt_pkg::*;
#(
    parameter int          CNT_W      = 12,
    parameter int          PSC_W      = 3,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 3,
    parameter int          KEY_W      = 16,
    parameter logic [15:0] UNLOCK_KEY = 16'h35CA,
    parameter logic [15:0] RELOAD_KEY = 16'h5FA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata,
    input  logic              sleep_i,
    input  logic              dbg_halt_i,
    output logic              wdt_rst_o
);
    logic [CNT_W-1:0] reload_val, delta, count_q;
    logic [PSC_W-1:0] psc;
    logic             ren, shlt, dbg_en, prot;
    logic             uf_flag, err_flag;
    logic             uf_evt, err_evt, tick, freeze, reload_cmd;
    wdt_state_e       state_q, state_d;

    assign reload_cmd = wr_en && (addr == ADDR_W'(ADR_CMD)) && wdata[0]
                        && (wdata[DATA_W-1 -: KEY_W] == RELOAD_KEY);
    assign freeze = (sleep_i && shlt) || (dbg_halt_i && dbg_en);

    wdt_regfile #(
        .CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .uf_evt_i(uf_evt), .err_evt_i(err_evt),
        .reload_val_o(reload_val), .delta_o(delta), .psc_o(psc),
        .ren_o(ren), .shlt_o(shlt), .dbg_en_o(dbg_en), .prot_o(prot),
        .uf_flag_o(uf_flag), .err_flag_o(err_flag)
    );

    wdt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run_i(!freeze), .clr_i(reload_cmd),
        .sel_i(psc), .tick_o(tick)
    );

    wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reload_i(reload_cmd),
        .reload_val_i(reload_val), .delta_i(delta), .count_o(count_q),
        .uf_evt_o(uf_evt), .err_evt_o(err_evt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (uf_evt || err_evt) state_d = ST_TRIP;
                else if (freeze)       state_d = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (uf_evt || err_evt) state_d = ST_TRIP;
                else if (!freeze)      state_d = ST_RUN;
            end
            ST_TRIP: begin
                if (uf_evt || err_evt) state_d = ST_TRIP;
                else if (freeze)       state_d = ST_FROZEN;
                else                   state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        wdt_rst_o = (state_q == ST_TRIP) && ren;
    end

    always_comb begin
        rdata = '0;
        case (int'(rd_addr))
            ADR_CFGA: begin
                rdata[CNT_W-1:0]     = reload_val;
                rdata[CFGA_REN_BIT]  = ren;
                rdata[CFGA_SHLT_BIT] = shlt;
                rdata[CFGA_DBG_BIT]  = dbg_en;
            end
            ADR_CFGB: begin
                rdata[CNT_W-1:0]             = delta;
                rdata[CFGB_PSC_LSB +: PSC_W] = psc;
            end
            ADR_LOCK: rdata[0] = prot;
            ADR_STAT: begin
                rdata[0] = uf_flag;
                rdata[1] = err_flag;
            end
            ADR_CNT:  rdata[CNT_W-1:0] = count_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wbit0,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  reload_val,
    input logic [CNT_W-1:0]  delta,
    input logic              tick,
    input logic              reload_cmd,
    input logic              freeze,
    input logic              uf_evt,
    input logic              err_evt,
    input logic              uf_flag,
    input logic              err_flag,
    input logic              prot,
    input logic              ren,
    input logic              rst_o
);
    // R3: locked config write leaves reload value unchanged
    a_r3_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (prot && wr_en && addr == ADDR_W'(ADR_CFGA)) |=> reload_val == $past(reload_val));

    // R5: count moves only on a prescaler tick or a reload
    a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reload_cmd) |=> count == $past(count));

    // R6: underflow reloads and flags
    a_r6_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> (count == $past(reload_val)) && uf_flag);

    // R7: window error raises the flag; disabled window never errors
    a_r7_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> err_flag);
    a_r7_window_off: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_cmd && delta >= reload_val) |-> !err_evt);

    // R8: underflow flag only falls after a clearing status write
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uf_flag) |-> $past(wr_en && addr == ADDR_W'(ADR_STAT) && wbit0));

    // R9: reset pulse follows an event and needs the enable
    a_r9_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |-> ($past(uf_evt || err_evt) && ren));

    // R10 and R11: gated halts hold the count
    a_r10_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !reload_cmd) |=> count == $past(count));
endmodule

bind wdt_window_top wdt_window_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wbit0(wdata[0]),
    .count(count_q), .reload_val(reload_val), .delta(delta), .tick(tick),
    .reload_cmd(reload_cmd), .freeze(freeze), .uf_evt(uf_evt), .err_evt(err_evt),
    .uf_flag(uf_flag), .err_flag(err_flag), .prot(prot), .ren(ren),
    .rst_o(wdt_rst_o)
);

// File: tb/tb_wdt_window_top.sv
`timescale 1ns/100ps
module tb_wdt_window_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rdata;
    logic        sleep_i = 1'b0;
    logic        dbg_halt_i = 1'b0;
    logic        wdt_rst_o;

    int    errors = 0;
    int    checks = 0;
    string req = "R1";

    always #2.5 clk = ~clk;

    wdt_window_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_addr(rd_addr), .rdata(rdata), .sleep_i(sleep_i),
        .dbg_halt_i(dbg_halt_i), .wdt_rst_o(wdt_rst_o)
    );

    // behavioural reference
    logic [11:0] m_reload, m_delta, m_cnt;
    int          m_psc, m_pre;
    bit          m_ren, m_shlt, m_den, m_prot, m_uf, m_err, m_rst;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reload = 12'hFFF; m_delta = 12'hFFF; m_cnt = 12'hFFF;
            m_psc = 7; m_pre = 0;
            m_ren = 0; m_shlt = 0; m_den = 0; m_prot = 0;
            m_uf = 0; m_err = 0; m_rst = 0;
        end else begin
            bit frz, cmd, tk, euf, eerr;
            int div;
            frz  = (sleep_i && m_shlt) || (dbg_halt_i && m_den);
            cmd  = wr_en && addr == 3'd0 && wdata[0] && wdata[31:16] == 16'h5FA0;
            div  = 1 << m_psc;
            tk   = !frz && ((m_pre % div) == div - 1);
            euf  = 0;
            eerr = 0;
            if (cmd) begin
                if (m_delta < m_reload && m_cnt > m_delta) eerr = 1;
                m_cnt = m_reload;
                m_pre = 0;
            end else if (!frz) begin
                if (tk) begin
                    if (m_cnt == 0) begin m_cnt = m_reload; euf = 1; end
                    else m_cnt = m_cnt - 1;
                end
                m_pre = (m_pre + 1) % 128;
            end
            if (wr_en && addr == 3'd4) begin
                if (wdata[0]) m_uf = 0;
                if (wdata[1]) m_err = 0;
            end
            if (euf)  m_uf = 1;
            if (eerr) m_err = 1;
            if (wr_en && !m_prot && addr == 3'd1) begin
                m_reload = wdata[11:0];
                m_ren = wdata[16]; m_shlt = wdata[17]; m_den = wdata[18];
            end
            if (wr_en && !m_prot && addr == 3'd2) begin
                m_delta = wdata[11:0];
                m_psc = int'(wdata[14:12]);
            end
            if (wr_en && addr == 3'd3) m_prot = (wdata[15:0] != 16'h35CA);
            m_rst = (euf || eerr) && m_ren;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            3'd1: begin v[11:0] = m_reload; v[16] = m_ren; v[17] = m_shlt; v[18] = m_den; end
            3'd2: begin v[11:0] = m_delta; v[14:12] = 3'(m_psc); end
            3'd3: v[0] = m_prot;
            3'd4: begin v[0] = m_uf; v[1] = m_err; end
            3'd5: v[11:0] = m_cnt;
            default: v = '0;
        endcase
        return v;
    endfunction

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rdata !== exp_rd(rd_addr)) begin
                errors++;
                $display("FAIL %s rdata@%0d actual=%h expected=%h", req, rd_addr, rdata, exp_rd(rd_addr));
            end
            checks++;
            if (wdt_rst_o !== m_rst) begin
                errors++;
                $display("FAIL %s wdt_rst_o actual=%b expected=%b", req, wdt_rst_o, m_rst);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic look(input logic [2:0] a);
        @(negedge clk); #1;
        rd_addr = a;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reload_cmd();
        wr(3'd0, 32'h5FA0_0001);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values of every register
        req = "R1";
        for (int a = 0; a < 6; a++) look(3'(a));
        // R5 prescaler exponents 0, 2, 7
        req = "R5";
        wr(3'd2, 32'h0000_0FFF);
        wr(3'd1, 32'h0000_0014);
        reload_cmd();
        look(3'd5); idle(15);
        wr(3'd2, 32'h0000_2FFF); reload_cmd(); idle(60);
        wr(3'd2, 32'h0000_7FFF); reload_cmd(); idle(300);
        // R4 key and request bit both needed
        req = "R4";
        wr(3'd2, 32'h0000_0FFF); reload_cmd(); idle(4);
        wr(3'd0, 32'h5FA1_0001); idle(3);
        wr(3'd0, 32'h5FA0_0000); idle(3);
        reload_cmd(); idle(3);
        // R6 underflow and auto reload
        req = "R6";
        look(3'd4); idle(30);
        look(3'd5); idle(25);
        // R8 sticky flags cleared by writing one
        req = "R8";
        look(3'd4); idle(5);
        wr(3'd4, 32'h0000_0002); idle(2);
        wr(3'd4, 32'h0000_0001); idle(2);
        // R7 window error
        req = "R7";
        wr(3'd2, 32'h0000_0005);
        reload_cmd(); reload_cmd(); idle(2);
        wr(3'd4, 32'h0000_0002);
        reload_cmd(); idle(16); reload_cmd(); idle(2);
        wr(3'd2, 32'h0000_001E);
        reload_cmd(); reload_cmd(); idle(2);
        // R9 reset pulse with enable on, none with enable off
        req = "R9";
        wr(3'd1, 32'h0001_0014);
        look(3'd5); idle(30);
        wr(3'd2, 32'h0000_0005); reload_cmd(); reload_cmd(); idle(3);
        wr(3'd1, 32'h0000_0014); reload_cmd(); idle(30);
        // R10 sleep halt
        req = "R10";
        wr(3'd1, 32'h0002_0014); idle(3);
        @(negedge clk); #1 sleep_i = 1'b1; idle(20);
        @(negedge clk); #1 sleep_i = 1'b0; idle(10);
        wr(3'd1, 32'h0000_0014);
        @(negedge clk); #1 sleep_i = 1'b1; idle(10);
        @(negedge clk); #1 sleep_i = 1'b0;
        // R11 debug halt
        req = "R11";
        wr(3'd1, 32'h0004_0014); idle(3);
        @(negedge clk); #1 dbg_halt_i = 1'b1; idle(15);
        @(negedge clk); #1 dbg_halt_i = 1'b0; idle(5);
        wr(3'd1, 32'h0000_0014);
        @(negedge clk); #1 dbg_halt_i = 1'b1; idle(8);
        @(negedge clk); #1 dbg_halt_i = 1'b0;
        // R2 lock key
        req = "R2";
        look(3'd3);
        wr(3'd3, 32'h0000_1234); idle(2);
        // R3 locked configuration
        req = "R3";
        wr(3'd1, 32'h0001_0033); look(3'd1); idle(2);
        wr(3'd2, 32'h0000_5003); look(3'd2); idle(2);
        look(3'd5); reload_cmd(); idle(3);
        req = "R2";
        wr(3'd3, 32'h0000_35CA); look(3'd3); idle(2);
        wr(3'd3, 32'h0000_35CB); idle(2);
        wr(3'd3, 32'h0000_35CA); idle(1);
        req = "R3";
        wr(3'd1, 32'h0000_0033); look(3'd1); idle(2);
        look(3'd5); idle(10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule